// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This block is a 32-bit combinational arithmetic datapath with one registered status bit. A 4-bit opcode selects one of ten operations on operands A and B: signed saturating add and subtract, a wrapping add that still reports signed overflow, signed doubling with clamping, unsigned saturating add and subtract, and clamping of A to a chosen bit width, signed or unsigned, over the whole word or over two independent 16-bit halves.

Whenever an operation has to clamp, or the wrapping add overflows, the block raises an internal overflow event. If the operation is issued (`op_en` high), that event sets a sticky flag. Arithmetic never clears the flag. Only a synchronous clear input or reset brings it back to zero. The result is combinational from the inputs. The flag changes on the clock edge that follows the issuing cycle.

Top module: `sat_alu`

## Requirements
- R1: Opcode 4'h0 gives A+B as signed numbers. When A and B share a sign and the sum's sign differs from A's, the result is 32'h7FFFFFFF if A is non-negative and 32'h80000000 if A is negative, and an overflow event occurs.
- R2: Opcode 4'h1 gives A-B as signed numbers. When A and B differ in sign and the difference's sign differs from A's, the result clamps to the same two values chosen by A's sign, and an overflow event occurs.
- R3: Opcode 4'h9 returns the wrapped 32-bit sum A+B unchanged, and still raises an overflow event under the signed-add overflow condition of R1.
- R4: Opcode 4'h2 doubles A. If A is at least 32'h40000000 (signed), the result is 32'h7FFFFFFF. If A is at most 32'hC0000000 (signed, boundary included), the result is 32'h80000000. Both cases are overflow events. Otherwise the result is A shifted left by one.
- R5: Opcode 4'h3 gives unsigned A+B, or all ones with an overflow event when the sum does not fit in 32 bits.
- R6: Opcode 4'h4 gives unsigned A-B, or zero with an overflow event when B exceeds A.
- R7: Opcode 4'h5 clamps signed A to the range -(2^s) to 2^s-1, where s is `sat_w` (0 to 31). A value outside that range is an overflow event.
- R8: Opcode 4'h6 clamps signed A to the range 0 to 2^s-1. A negative A gives 0, a larger A gives 2^s-1, and both are overflow events.
- R9: Opcode 4'h7 applies the R7 clamp to each sign-extended 16-bit half of A (bits 15:0 and 31:16) separately. The low 16 bits of each lane's result go back into that lane's half. A clamp in either lane is an overflow event.
- R10: Opcode 4'h8 applies the R8 clamp per half in the same way as R9.
- R11: `q_flag` becomes 1 on the clock edge after a cycle in which `op_en` is high and an overflow event occurs. Once set, it stays 1 whatever later operations do. Overflow events while `op_en` is low leave the flag unchanged.
- R12: `clr_q` clears the flag on the next edge and takes priority over a simultaneous set. An active-low `rst_n` clears it asynchronously.
- R13: Opcodes 4'hA to 4'hF give a zero result and never raise an overflow event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag |
| op_en | input | 1 | Operation issued this cycle; lets an overflow event set the flag |
| op | input | 4 | Operation select |
| a | input | 32 | Operand A |
| b | input | 32 | Operand B |
| sat_w | input | 5 | Clamp width s for opcodes 4'h5 to 4'h8 |
| clr_q | input | 1 | Synchronous clear of the sticky flag |
| result | output | 32 | Combinational result |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
Each add and subtract opcode is driven with operand pairs that overflow toward the positive limit, toward the negative limit, and with mixed or harmless signs. This shows that the clamp value follows A's sign and that overflow detection depends on the operand signs. Doubling is tried just below, at, and just above both of its thresholds, including the inclusive negative boundary. The width clamps run with s = 0, 7, 8, 15 and 31, on values one step inside and one step outside the range. The halfword forms use patterns where only one lane clamps, both lanes clamp in opposite directions, or neither lane clamps. Directed sequences on the flag separate sticky holding, an issue gated by `op_en`, clear-versus-set priority and reset.

// File: rtl/sat_pkg.sv
package sat_pkg;

  localparam int WORD_W = 32;
  localparam int SATW_W = 5;
  localparam int LANES  = 2;

  typedef enum logic [3:0] {
    OP_SADD   = 4'h0,
    OP_SSUB   = 4'h1,
    OP_SDBL   = 4'h2,
    OP_UADD   = 4'h3,
    OP_USUB   = 4'h4,
    OP_CLMPS  = 4'h5,
    OP_CLMPU  = 4'h6,
    OP_CLMPS2 = 4'h7,
    OP_CLMPU2 = 4'h8,
    OP_WADD   = 4'h9
  } sat_op_e;

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int W = sat_pkg::WORD_W
) (
  input  sat_pkg::sat_op_e opc,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     res,
  output logic             ovf
);
  import sat_pkg::*;

  localparam logic signed [W-1:0] QTR_POS = W'(1) <<< (W - 2);
  localparam logic signed [W-1:0] QTR_NEG = -QTR_POS;
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  // clamp value chosen by the sign of the first operand
  function automatic logic [W-1:0] signed_limit(input logic neg);
    return neg ? S_MIN : S_MAX;
  endfunction

  function automatic logic add_overflows(input logic [W-1:0] x, y, s);
    return (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
  endfunction

  function automatic logic sub_overflows(input logic [W-1:0] x, y, d);
    return (x[W-1] != y[W-1]) && (d[W-1] != x[W-1]);
  endfunction

  logic [W:0]   usum;
  logic [W-1:0] diff;
  logic         sadd_ovf, ssub_ovf, uadd_ovf, usub_ovf;
  logic         dbl_hi, dbl_lo;

  assign usum     = {1'b0, a} + {1'b0, b};
  assign diff     = a - b;
  assign sadd_ovf = add_overflows(a, b, usum[W-1:0]);
  assign ssub_ovf = sub_overflows(a, b, diff);
  assign uadd_ovf = usum[W];
  assign usub_ovf = (a < b);
  assign dbl_hi   = ($signed(a) >= QTR_POS);
  assign dbl_lo   = ($signed(a) <= QTR_NEG);

  always_comb begin
    res = '0;
    ovf = 1'b0;
    case (opc)
      OP_SADD: begin
        ovf = sadd_ovf;
        res = sadd_ovf ? signed_limit(a[W-1]) : usum[W-1:0];
      end
      OP_WADD: begin
        ovf = sadd_ovf;
        res = usum[W-1:0];
      end
      OP_SSUB: begin
        ovf = ssub_ovf;
        res = ssub_ovf ? signed_limit(a[W-1]) : diff;
      end
      OP_SDBL: begin
        ovf = dbl_hi | dbl_lo;
        if (dbl_hi)      res = S_MAX;
        else if (dbl_lo) res = S_MIN;
        else             res = {a[W-2:0], 1'b0};
      end
      OP_UADD: begin
        ovf = uadd_ovf;
        res = uadd_ovf ? {W{1'b1}} : usum[W-1:0];
      end
      OP_USUB: begin
        ovf = usub_ovf;
        res = usub_ovf ? '0 : diff;
      end
      default: begin
        res = '0;
        ovf = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int W  = sat_pkg::WORD_W,
  parameter int SW = sat_pkg::SATW_W,
  parameter int RW = W
) (
  input  logic          signed_mode,
  input  logic [SW-1:0] s,
  input  logic [W-1:0]  val,
  output logic [RW-1:0] res,
  output logic          ovf
);
  logic signed [W-1:0] top;
  logic [W-1:0]        mask;
  logic                s_hi, s_lo, u_neg, u_big;

  // 2^s - 1: upper bound of both clamp forms
  function automatic logic [W-1:0] low_ones(input logic [SW-1:0] n);
    return (W'(1) << n) - W'(1);
  endfunction

  assign mask  = low_ones(s);
  assign top   = $signed(val) >>> s;
  assign s_hi  = (top > $signed(W'(0)));
  assign s_lo  = (top < $signed({W{1'b1}}));
  assign u_neg = val[W-1];
  assign u_big = !val[W-1] && (val > mask);

  assign ovf = signed_mode ? (s_hi | s_lo) : (u_neg | u_big);
  assign res = signed_mode ?
               RW'(s_hi ? mask : (s_lo ? ~mask : val)) :
               RW'(u_neg ? '0 : (u_big ? mask : val));

endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int W  = sat_pkg::WORD_W,
  parameter int SW = sat_pkg::SATW_W,
  parameter int NL = sat_pkg::LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_en,
  input  logic [3:0]    op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [SW-1:0] sat_w,
  input  logic          clr_q,
  output logic [W-1:0]  result,
  output logic          q_flag
);
  import sat_pkg::*;

  localparam int LW = W / NL;

  sat_op_e      opc;
  logic [W-1:0] as_res, wc_res, lane_pack;
  logic         as_ovf, wc_ovf;
  logic [NL-1:0] lane_ovf;
  logic         ovf_any;
  logic         flag_set;

  assign opc = sat_op_e'(op);

  sat_addsub #(.W(W)) u_addsub (
    .opc(opc), .a(a), .b(b), .res(as_res), .ovf(as_ovf)
  );

  sat_clamp #(.W(W), .SW(SW), .RW(W)) u_word (
    .signed_mode(opc == OP_CLMPS), .s(sat_w), .val(a),
    .res(wc_res), .ovf(wc_ovf)
  );

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [W-1:0] ext;
    assign ext = {{(W-LW){a[g*LW+LW-1]}}, a[g*LW +: LW]};
    sat_clamp #(.W(W), .SW(SW), .RW(LW)) u_lane (
      .signed_mode(opc == OP_CLMPS2), .s(sat_w), .val(ext),
      .res(lane_pack[g*LW +: LW]), .ovf(lane_ovf[g])
    );
  end

  always_comb begin
    case (opc)
      OP_SADD, OP_SSUB, OP_SDBL, OP_UADD, OP_USUB, OP_WADD: begin
        result  = as_res;
        ovf_any = as_ovf;
      end
      OP_CLMPS, OP_CLMPU: begin
        result  = wc_res;
        ovf_any = wc_ovf;
      end
      OP_CLMPS2, OP_CLMPU2: begin
        result  = lane_pack;
        ovf_any = |lane_ovf;
      end
      default: begin
        result  = '0;
        ovf_any = 1'b0;
      end
    endcase
  end

  assign flag_set = op_en & ovf_any;

  sat_sticky u_flag (
    .clk(clk), .rst_n(rst_n), .clr(clr_q), .set(flag_set), .flag(q_flag)
  );

endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_en,
  input logic [3:0]   op,
  input logic         clr_q,
  input logic [W-1:0] result,
  input logic         q_flag,
  input logic         ovf_any
);
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  // R11: once set and not cleared, the flag holds
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    q_flag && !clr_q |=> q_flag);

  // R11: issued overflow sets the flag
  a_r11_set: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && ovf_any && !clr_q |=> q_flag);

  // R11: no issued overflow, flag does not rise
  a_r11_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !q_flag && !(op_en && ovf_any) |=> !q_flag);

  // R12: clear wins
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !q_flag);

  // R12: flag low when reset releases
  a_r12_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !q_flag);

  // R1: clamped signed add lands on a limit
  a_r1_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'h0) && ovf_any |-> (result == S_MAX) || (result == S_MIN));

  // R5: unsigned add clamp is all ones
  a_r5_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'h3) && ovf_any |-> result == {W{1'b1}});

  // R6: unsigned subtract clamp is zero
  a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'h4) && ovf_any |-> result == '0);

  // R13: unused opcodes are quiet
  a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 4'hA) |-> (result == '0) && !ovf_any);

endmodule

bind sat_alu sat_alu_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_en(op_en), .op(op), .clr_q(clr_q),
  .result(result), .q_flag(q_flag), .ovf_any(ovf_any)
);

// File: tb/sat_alu_tb_top.sv
module sat_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_en = 1'b0;
  logic [3:0]  op = 4'h0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [4:0]  sat_w = '0;
  logic        clr_q = 1'b0;
  logic [31:0] result;
  logic        q_flag;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sat_alu dut_i (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op(op), .a(a), .b(b),
    .sat_w(sat_w), .clr_q(clr_q), .result(result), .q_flag(q_flag)
  );

  // {op, s, a, b, expected result, expected flag}
  localparam int NV = 36;
  localparam logic [105:0] VECS [NV] = '{
    {4'h0, 5'd0, 32'h00000005, 32'h00000003, 32'h00000008, 1'b0},
    {4'h0, 5'd0, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1},
    {4'h0, 5'd0, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1},
    {4'h0, 5'd0, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 1'b0},
    {4'h1, 5'd0, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1},
    {4'h1, 5'd0, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1},
    {4'h1, 5'd0, 32'h00000010, 32'h00000003, 32'h0000000D, 1'b0},
    {4'h9, 5'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1},
    {4'h9, 5'd0, 32'h00000002, 32'h00000003, 32'h00000005, 1'b0},
    {4'h2, 5'd0, 32'h3FFFFFFF, 32'h0, 32'h7FFFFFFE, 1'b0},
    {4'h2, 5'd0, 32'h40000000, 32'h0, 32'h7FFFFFFF, 1'b1},
    {4'h2, 5'd0, 32'hC0000000, 32'h0, 32'h80000000, 1'b1},
    {4'h2, 5'd0, 32'hC0000001, 32'h0, 32'h80000002, 1'b0},
    {4'h3, 5'd0, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 1'b1},
    {4'h3, 5'd0, 32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFF, 1'b0},
    {4'h4, 5'd0, 32'h00000000, 32'h00000001, 32'h00000000, 1'b1},
    {4'h4, 5'd0, 32'h00000005, 32'h00000005, 32'h00000000, 1'b0},
    {4'h5, 5'd7, 32'h0000007F, 32'h0, 32'h0000007F, 1'b0},
    {4'h5, 5'd7, 32'h00000080, 32'h0, 32'h0000007F, 1'b1},
    {4'h5, 5'd7, 32'hFFFFFF80, 32'h0, 32'hFFFFFF80, 1'b0},
    {4'h5, 5'd7, 32'hFFFFFF7F, 32'h0, 32'hFFFFFF80, 1'b1},
    {4'h5, 5'd0, 32'h00000005, 32'h0, 32'h00000000, 1'b1},
    {4'h5, 5'd0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 1'b0},
    {4'h6, 5'd8, 32'h000000FF, 32'h0, 32'h000000FF, 1'b0},
    {4'h6, 5'd8, 32'h00000100, 32'h0, 32'h000000FF, 1'b1},
    {4'h6, 5'd8, 32'hFFFFFFFF, 32'h0, 32'h00000000, 1'b1},
    {4'h6, 5'd31, 32'h80000000, 32'h0, 32'h00000000, 1'b1},
    {4'h6, 5'd31, 32'h7FFFFFFF, 32'h0, 32'h7FFFFFFF, 1'b0},
    {4'h7, 5'd7, 32'h0100FF00, 32'h0, 32'h007FFF80, 1'b1},
    {4'h7, 5'd7, 32'h0050FFC0, 32'h0, 32'h0050FFC0, 1'b0},
    {4'h7, 5'd15, 32'h80007FFF, 32'h0, 32'h80007FFF, 1'b0},
    {4'h8, 5'd8, 32'h80000123, 32'h0, 32'h000000FF, 1'b1},
    {4'h8, 5'd8, 32'h00FF0010, 32'h0, 32'h00FF0010, 1'b0},
    {4'h8, 5'd4, 32'h00050F00, 32'h0, 32'h0005000F, 1'b1},
    {4'hA, 5'd0, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 1'b0},
    {4'hF, 5'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0}
  };

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'h0: return "R1";
      4'h1: return "R2";
      4'h2: return "R4";
      4'h3: return "R5";
      4'h4: return "R6";
      4'h5: return "R7";
      4'h6: return "R8";
      4'h7: return "R9";
      4'h8: return "R10";
      4'h9: return "R3";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clear;
    op_en = 1'b0;
    clr_q = 1'b1;
    tick();
    clr_q = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    tick();
    tick();
    // R12: reset state
    check("R12 reset flag", {31'b0, q_flag}, 32'h0);
    rst_n = 1'b1;
    tick();
    check("R12 flag after release", {31'b0, q_flag}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [105:0] v;
      v = VECS[i];
      op = v[105:102]; sat_w = v[101:97]; a = v[96:65]; b = v[64:33];
      op_en = 1'b1;
      #1;
      check({req_of(v[105:102]), " result"}, result, v[32:1]);
      tick();
      // R11: flag reflects whether this issued op overflowed
      check({req_of(v[105:102]), " flag R11"}, {31'b0, q_flag}, {31'b0, v[0]});
      pulse_clear();
    end

    // R11: sticky across a later non-overflowing op
    op = 4'h0; a = 32'h7FFFFFFF; b = 32'h1; op_en = 1'b1;
    tick();
    a = 32'h1; b = 32'h1;
    tick();
    check("R11 sticky hold", {31'b0, q_flag}, 32'h1);
    pulse_clear();
    check("R12 clear alone", {31'b0, q_flag}, 32'h0);

    // R11: overflow without issue does not set
    op = 4'h3; a = 32'hFFFFFFFF; b = 32'h1; op_en = 1'b0;
    #1;
    check("R5 result with op_en low", result, 32'hFFFFFFFF);
    tick();
    check("R11 gated by op_en", {31'b0, q_flag}, 32'h0);

    // R12: clear beats simultaneous set
    op_en = 1'b1; clr_q = 1'b1;
    tick();
    check("R12 clear priority", {31'b0, q_flag}, 32'h0);
    clr_q = 1'b0;
    tick();
    check("R11 set after clear drop", {31'b0, q_flag}, 32'h1);

    // R12: reset mid-run
    op_en = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R12 async reset", {31'b0, q_flag}, 32'h0);
    tick();
    rst_n = 1'b1;
    tick();

    // R13: unused opcode issued does not set
    op = 4'hC; a = 32'h80000000; b = 32'h7FFFFFFF; op_en = 1'b1;
    #1;
    check("R13 unused result", result, 32'h0);
    tick();
    check("R13 unused flag", {31'b0, q_flag}, 32'h0);
    op_en = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<5000 cycles", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule